// File: doc/BRIEF.md
# Display Controller Serial Register Access Master

This block lets on-chip logic configure a display controller whose serial control port frames every transfer with a leading start byte. The host presents one command at a time together with an 8-bit register offset and a 16-bit write value. A command is one of four kinds: select an index, write a register, read a register, or read the status word. The block then produces chip select, serial clock and serial data out. It samples serial data in, and it returns a 16-bit result together with a one-cycle completion pulse.

A register write or read is split into two chip-select frames. The first frame loads the index register and the second frame moves the data. Chip select returns high between the two frames and after the last one. The start byte of each frame carries a fixed 5-bit prefix, a device identifier bit, a bit that selects index or data, and a read/write bit. A status read is a single longer frame in which the first received byte after the start byte is thrown away. A configuration input can complement every transmitted byte for links with an inverting buffer.

Top module: `dspi_reg_master`

## Requirements
- R1: The first byte of every frame is {5'b01110, ID, SEL, DIR}: bits 7:3 are 01110, bit 2 is the latched `cfg_id`, bit 1 is SEL (0 = index, 1 = data) and bit 0 is DIR (0 = write, 1 = read).
- R2: An index command (`cmd_op` = 0) sends one 3-byte frame: start byte with SEL=0 and DIR=0, then 0x00, then the register offset.
- R3: A write command (`cmd_op` = 1) sends the index frame of R2, then a second 3-byte frame: start byte with SEL=1 and DIR=0, the high data byte, then the low data byte.
- R4: A read command (`cmd_op` = 2) sends the index frame of R2, then a 3-byte frame with start byte SEL=1, DIR=1 followed by two 0x00 bytes; `rd_data` is received bytes 1 and 2 of that frame, high byte first.
- R5: A status command (`cmd_op` = 3) sends one 4-byte frame: start byte with SEL=0, DIR=1, then three 0x00 bytes; received byte 1 is discarded and `rd_data` is received bytes 2 and 3, high byte first.
- R6: Chip select stays high for at least GAP_HALVES serial-clock half periods between the frames of a command and after its final frame.
- R7: When `cfg_invert` is 1 at command acceptance, every transmitted byte, the start byte included, is bitwise complemented.
- R8: Transfers use SPI mode 0, most significant bit first: the serial clock idles low whenever chip select is high, data in is sampled on the rising edge, and each clock level lasts HALF_DIV system clock cycles.
- R9: `busy` is 1 from the cycle after a command is accepted until `done`; `done` is a single-cycle pulse; a command presented while `busy` is 1 is ignored and produces no frame.
- R10: After reset, chip select is high, serial clock is low, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | 0 index, 1 write, 2 read, 3 status |
| cmd_reg | input | 8 | Register offset |
| cmd_wdata | input | 16 | Value for write commands |
| cfg_id | input | 1 | Device identifier bit placed in start bytes |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read or status result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the display |
| spi_miso | input | 1 | Serial data from the display |

## Verification
All four command kinds are swept against both identifier values and both inversion settings, with offsets and write values that include all-zeros, all-ones and alternating patterns. This separates a bit that is misplaced in the start byte from a byte that is missing or reordered, and it exposes an inversion that skips the filler bytes. A serial slave model returns a different byte at each position, so taking the result from the wrong byte, the wrong frame or in the wrong byte order gives a visibly wrong value. Clock half periods and chip-select gaps are measured at the pins. One command is issued while the block is busy, and the frames that follow show that it was dropped.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;
   localparam logic [4:0] START_PREFIX = 5'b01110;

   typedef enum logic [1:0] {
      OP_INDEX  = 2'd0,
      OP_WRITE  = 2'd1,
      OP_READ   = 2'd2,
      OP_STATUS = 2'd3
   } dspi_op_e;

   typedef enum logic [1:0] {
      FR_INDEX  = 2'd0,
      FR_WDATA  = 2'd1,
      FR_RDATA  = 2'd2,
      FR_STATUS = 2'd3
   } dspi_frame_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } dspi_state_e;

   function automatic logic [BYTE_W-1:0] start_byte(input logic id, input logic sel,
                                                    input logic dir);
      return {START_PREFIX, id, sel, dir};
   endfunction

   function automatic logic [BYTE_W-1:0] frame_byte(input dspi_frame_e fr,
                                                    input logic [1:0] idx,
                                                    input logic id,
                                                    input logic [BYTE_W-1:0] offs,
                                                    input logic [WORD_W-1:0] wd,
                                                    input logic inv);
      logic [BYTE_W-1:0] raw;
      raw = '0;
      unique case (fr)
         FR_INDEX:  raw = (idx == 2'd0) ? start_byte(id, 1'b0, 1'b0) :
                          (idx == 2'd2) ? offs : '0;
         FR_WDATA:  raw = (idx == 2'd0) ? start_byte(id, 1'b1, 1'b0) :
                          (idx == 2'd1) ? wd[WORD_W-1:BYTE_W] : wd[BYTE_W-1:0];
         FR_RDATA:  raw = (idx == 2'd0) ? start_byte(id, 1'b1, 1'b1) : '0;
         FR_STATUS: raw = (idx == 2'd0) ? start_byte(id, 1'b0, 1'b1) : '0;
         default:   raw = '0;
      endcase
      return inv ? ~raw : raw;
   endfunction

endpackage

// File: rtl/dspi_tick.sv
module dspi_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("dspi_tick: HALF_DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run)          cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);

   generate
      if (HALF_DIV > 1) begin : g_spaced
         // R8: a clock level never lasts only one cycle when the divider is above one
         a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/dspi_shift_byte.sv
module dspi_shift_byte
   import dspi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              shift_out,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi,
   output logic [BYTE_W-1:0] rx_byte
);
   logic [BYTE_W-1:0] tx_q;
   logic [BYTE_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tx_q <= '0;
      else if (load)      tx_q <= load_byte;
      else if (shift_out) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_q <= '0;
      else if (sample) rx_q <= {rx_q[BYTE_W-2:0], miso};
   end

   assign mosi    = tx_q[BYTE_W-1];
   assign rx_byte = rx_q;

   // R8: loading a new byte and shifting the current one never coincide
   a_r8_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift_out));

endmodule

// File: rtl/dspi_reg_master.sv
module dspi_reg_master
   import dspi_pkg::*;
#(
   parameter int HALF_DIV   = 2,
   parameter int GAP_HALVES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_op,
   input  logic [7:0]  cmd_reg,
   input  logic [15:0] cmd_wdata,
   input  logic        cfg_id,
   input  logic        cfg_invert,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        spi_cs_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int GW      = $clog2(GAP_HALVES + 1);
   localparam int GAP_CYC = GAP_HALVES * HALF_DIV;
   localparam int HW      = $clog2(GAP_CYC + 1);

   generate
      if (GAP_HALVES < 2) begin : g_bad_gap
         $error("dspi_reg_master: GAP_HALVES must be at least 2");
      end
   endgenerate

   dspi_state_e       state_q;
   dspi_frame_e       frame_q;
   dspi_op_e          op_q;
   logic [BYTE_W-1:0] reg_q;
   logic [WORD_W-1:0] wdata_q;
   logic              id_q, inv_q;
   logic [1:0]        byte_q;
   logic [2:0]        bit_q;
   logic [GW-1:0]     gap_q;
   logic              sclk_q, cs_n_q, done_q;
   logic [WORD_W-1:0] result_q;

   logic              tick, run;
   logic              sh_load, sh_shift, sh_sample;
   logic [BYTE_W-1:0] sh_byte, rx_byte;
   logic              last_byte, gap_end, chain;
   dspi_frame_e       first_fr, second_fr;

   assign run       = (state_q != ST_IDLE);
   assign first_fr  = (dspi_op_e'(cmd_op) == OP_STATUS) ? FR_STATUS : FR_INDEX;
   assign second_fr = (op_q == OP_WRITE) ? FR_WDATA : FR_RDATA;
   assign last_byte = (frame_q == FR_STATUS) ? (byte_q == 2'd3) : (byte_q == 2'd2);
   assign gap_end   = (gap_q == GW'(GAP_HALVES - 1));
   assign chain     = (frame_q == FR_INDEX) && (op_q != OP_INDEX);

   dspi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   dspi_shift_byte u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_byte(sh_byte),
      .shift_out(sh_shift),
      .sample   (sh_sample),
      .miso     (spi_miso),
      .mosi     (spi_mosi),
      .rx_byte  (rx_byte)
   );

   always_comb begin
      sh_load   = 1'b0;
      sh_shift  = 1'b0;
      sh_sample = 1'b0;
      sh_byte   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd_valid) begin
               sh_load = 1'b1;
               sh_byte = frame_byte(first_fr, 2'd0, cfg_id, cmd_reg, cmd_wdata, cfg_invert);
            end
         end
         ST_SHIFT: begin
            if (tick) begin
               if (!sclk_q)           sh_sample = 1'b1;
               else if (bit_q != 3'd7) sh_shift = 1'b1;
               else if (!last_byte) begin
                  sh_load = 1'b1;
                  sh_byte = frame_byte(frame_q, 2'(byte_q + 2'd1), id_q, reg_q, wdata_q, inv_q);
               end
            end
         end
         ST_GAP: begin
            if (tick && gap_end && chain) begin
               sh_load = 1'b1;
               sh_byte = frame_byte(second_fr, 2'd0, id_q, reg_q, wdata_q, inv_q);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         frame_q  <= FR_INDEX;
         op_q     <= OP_INDEX;
         reg_q    <= '0;
         wdata_q  <= '0;
         id_q     <= 1'b0;
         inv_q    <= 1'b0;
         byte_q   <= '0;
         bit_q    <= '0;
         gap_q    <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q    <= dspi_op_e'(cmd_op);
                  reg_q   <= cmd_reg;
                  wdata_q <= cmd_wdata;
                  id_q    <= cfg_id;
                  inv_q   <= cfg_invert;
                  frame_q <= first_fr;
                  byte_q  <= '0;
                  bit_q   <= '0;
                  sclk_q  <= 1'b0;
                  cs_n_q  <= 1'b0;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_q != 3'd7) begin
                        bit_q <= bit_q + 3'd1;
                     end else begin
                        result_q <= {result_q[BYTE_W-1:0], rx_byte};
                        bit_q    <= '0;
                        if (last_byte) begin
                           cs_n_q  <= 1'b1;
                           gap_q   <= '0;
                           state_q <= ST_GAP;
                        end else begin
                           byte_q <= byte_q + 2'd1;
                        end
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (!gap_end) begin
                     gap_q <= gap_q + 1'b1;
                  end else if (chain) begin
                     frame_q <= second_fr;
                     byte_q  <= '0;
                     bit_q   <= '0;
                     cs_n_q  <= 1'b0;
                     state_q <= ST_SHIFT;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = run;
   assign done     = done_q;
   assign rd_data  = result_q;
   assign spi_cs_n = cs_n_q;
   assign spi_sclk = sclk_q;

   // Chip-select high time, kept for the gap property
   logic [HW-1:0] hi_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         hi_cnt_q <= HW'(GAP_CYC);
      else if (!cs_n_q)                   hi_cnt_q <= '0;
      else if (hi_cnt_q != HW'(GAP_CYC))  hi_cnt_q <= hi_cnt_q + 1'b1;
   end

   // R6: chip select was high long enough before it falls again
   a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt_q >= HW'(GAP_CYC)));
   // R8: no clock activity while deselected
   a_r8_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);
   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: busy only ends with a completion
   a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R9: a command offered while busy leaves the captured command untouched
   a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> ($stable(op_q) && $stable(reg_q) && $stable(wdata_q)));

endmodule

// File: tb/dspi_reg_master_bench.sv
module dspi_reg_master_bench;
   localparam int HALF = 2;
   localparam int GAPH = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [7:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic        cfg_id = 1'b0, cfg_invert = 1'b0;
   logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;
   logic [15:0] rd_data;
   logic        miso_r = 1'b0;

   dspi_reg_master #(.HALF_DIV(HALF), .GAP_HALVES(GAPH)) u_dspi_reg_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cfg_id(cfg_id),
      .cfg_invert(cfg_invert), .busy(busy), .done(done), .rd_data(rd_data),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(miso_r)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Serial slave model
   logic [7:0] seed = 8'h00;
   logic [7:0] cap [0:3][0:3];
   int         flen [0:3];
   int         frc = 0, bitc = 0, bytec = 0;
   logic [7:0] sh = '0;
   logic       cs_p = 1'b1, sck_p = 1'b0;
   bit         in_fr = 1'b0;

   function automatic logic [7:0] reply(input int f, input int b);
      return seed ^ (8'(b + 1) * 8'h1D) ^ 8'(f * 64);
   endfunction

   always @(spi_cs_n or spi_sclk) begin
      logic [7:0] rb;
      if (spi_cs_n === 1'b0 && cs_p === 1'b1) begin
         in_fr = 1'b1; bitc = 0; bytec = 0;
         rb = reply(frc, 0);
         miso_r = rb[7];
      end else if (spi_cs_n === 1'b1 && cs_p === 1'b0 && in_fr) begin
         in_fr = 1'b0;
         if (frc < 4) flen[frc] = bytec;
         frc++;
      end
      if (in_fr && spi_cs_n === 1'b0) begin
         if (spi_sclk === 1'b1 && sck_p === 1'b0) begin
            sh = {sh[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
               if (frc < 4 && bytec < 4) cap[frc][bytec] = sh;
               bytec++; bitc = 0;
            end
         end else if (spi_sclk === 1'b0 && sck_p === 1'b1) begin
            if (bytec < 4) begin
               rb = reply(frc, bytec);
               miso_r = rb[7 - bitc];
            end
         end
      end
      cs_p  = spi_cs_n;
      sck_p = spi_sclk;
   end

   // Pin timing monitor
   int   hi_run = 0, min_gap = 1000, sck_run = 0, hp_min = 1000, hp_max = 0, idle_err = 0;
   logic sck_last = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_cs_n) begin
            hi_run++;
            if (spi_sclk) idle_err++;
            sck_run = 0;
         end else begin
            if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
            if (spi_sclk !== sck_last) begin
               if (sck_run < hp_min) hp_min = sck_run;
               if (sck_run > hp_max) hp_max = sck_run;
               sck_run = 1;
            end else sck_run++;
         end
         sck_last = spi_sclk;
      end
   end

   // Expected transmitted byte, from the frame layouts in the requirements
   function automatic logic [7:0] exp_byte(input int kind, input int idx, input logic id,
                                           input logic [7:0] offs, input logic [15:0] wd,
                                           input logic inv);
      logic [7:0] r;
      r = 8'h00;
      if (idx == 0)
         r = {5'b01110, id, logic'(kind == 1 || kind == 2), logic'(kind >= 2)};
      else if (kind == 0 && idx == 2) r = offs;
      else if (kind == 1 && idx == 1) r = wd[15:8];
      else if (kind == 1 && idx == 2) r = wd[7:0];
      return inv ? ~r : r;
   endfunction

   task automatic run_cmd(input logic [1:0] op, input logic [7:0] offs, input logic [15:0] wd,
                          input logic id, input logic inv, input logic [7:0] sd, input bit poke);
      string req;
      int    t, nexp, kinds[2], lens[2];
      logic [15:0] got;
      req  = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : (op == 2'd2) ? "R4" : "R5";
      seed = sd; frc = 0;
      for (int i = 0; i < 4; i++) flen[i] = 0;
      @(negedge clk);
      cmd_op = op; cmd_reg = offs; cmd_wdata = wd; cfg_id = id; cfg_invert = inv;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      cfg_id = ~id; cfg_invert = ~inv; cmd_reg = ~offs; cmd_wdata = ~wd;
      chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
      t = 0;
      while (!done && t < 5000) begin
         if (poke && t == 20) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
         if (poke && t == 22) cmd_valid = 1'b0;
         @(negedge clk);
         t++;
      end
      cmd_valid = 1'b0;
      chk(done == 1'b1, "R9", "done seen", done, 1);
      chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
      got = rd_data;
      @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle", done, 0);
      repeat (40) @(negedge clk);
      nexp = (op == 2'd1 || op == 2'd2) ? 2 : 1;
      chk(frc == nexp, poke ? "R9" : req, "frame count", frc, nexp);
      kinds[0] = (op == 2'd3) ? 3 : 0;
      kinds[1] = (op == 2'd1) ? 1 : 2;
      lens[0]  = (op == 2'd3) ? 4 : 3;
      lens[1]  = 3;
      for (int f = 0; f < nexp && f < frc; f++) begin
         chk(flen[f] == lens[f], req, "frame length", flen[f], lens[f]);
         for (int b = 0; b < lens[f] && b < flen[f]; b++) begin
            logic [7:0] e;
            e = exp_byte(kinds[f], b, id, offs, wd, inv);
            chk(cap[f][b] == e, (b == 0) ? "R1" : (inv ? "R7" : req),
                $sformatf("frame %0d byte %0d", f, b), cap[f][b], e);
         end
      end
      if (op == 2'd2)
         chk(got == {reply(1, 1), reply(1, 2)}, "R4", "read result", got, {reply(1, 1), reply(1, 2)});
      if (op == 2'd3)
         chk(got == {reply(0, 2), reply(0, 3)}, "R5", "status result", got, {reply(0, 2), reply(0, 3)});
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_900_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] pat;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(spi_cs_n == 1'b1, "R10", "cs_n in reset", spi_cs_n, 1);
      chk(spi_sclk == 1'b0, "R10", "sclk in reset", spi_sclk, 0);
      chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
      chk(done == 1'b0, "R10", "done in reset", done, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int id = 0; id < 2; id++)
         for (int inv = 0; inv < 2; inv++)
            for (int op = 0; op < 4; op++)
               for (int p = 0; p < 4; p++) begin
                  pat = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF :
                        (p == 2) ? 16'hA55A : 16'h12C7;
                  run_cmd(2'(op), 8'(p * 8'h45 + op), pat, 1'(id), 1'(inv),
                          8'(p * 16 + op * 4 + id * 2 + inv), 1'b0);
               end
      // R9: command offered mid-transfer must be dropped
      run_cmd(2'd1, 8'h3C, 16'hBEEF, 1'b1, 1'b0, 8'h5A, 1'b1);
      run_cmd(2'd2, 8'h81, 16'h0000, 1'b0, 1'b1, 8'hC3, 1'b1);
      // R6 and R8 measured at the pins over the whole run
      chk(min_gap >= GAPH * HALF, "R6", "minimum cs high", min_gap, GAPH * HALF);
      chk(hp_min == HALF, "R8", "shortest sclk level", hp_min, HALF);
      chk(hp_max == HALF, "R8", "longest sclk level", hp_max, HALF);
      chk(idle_err == 0, "R8", "sclk high while deselected", idle_err, 0);
      finish_run();
   end

endmodule